// File: doc/BRIEF.md
# Synchronous Serial Port Register and FIFO Front End

This block sits between a simple register bus and a serial shift engine. It holds the port's configuration (a frame-format word, a control word, a clock prescaler), eight-deep transmit and receive queues, a status word and an interrupt identify/clear register. Software writes transmit frames and reads received frames through one data address. The shift engine draws transmit frames and delivers received frames through single-cycle pop and push strobes.

Three interrupt sources are combined onto a single line, each behind its own enable. The receive source fires when the receive queue is at least half full. The transmit source fires when the transmit queue is at most half full. The overrun source is a latched flag, set when a frame arrives at a full receive queue. A loopback control feeds the engine's serial output back to its serial input. A port-enable control gates all engine-side traffic.

Top module: `ssp_regfile`

## Requirements
- R1: After reset the frame-format word, control word and prescaler read 0. Status reads 0x0003 (transmit empty and transmit not full). The interrupt line is low.
- R2: Byte offsets are decoded from addr[4:2]: 0x00 frame format (16 bits), 0x04 control (7 bits, upper bits read 0), 0x08 data, 0x0C status, 0x10 prescaler (8 bits), 0x14 interrupt identify/clear. Other offsets read 0. The frame-format and prescaler values appear on frame_cfg and clk_prescale.
- R3: A write to the data offset pushes one frame into the transmit queue. A push while 8 frames are held is ignored.
- R4: A read of the data offset returns and removes the oldest received frame. A read of an empty receive queue returns 0 and changes nothing.
- R5: Status bits: 0 transmit empty, 1 transmit not full, 2 receive not empty, 3 receive full, 4 busy. Busy is set when the port is enabled and either the transmit queue holds a frame or eng_busy is high.
- R6: Control bit 4 enables the port. While it is 0, tx_valid is low, tx_pop is ignored and rx_push is ignored.
- R7: Identify bit 0 is set when control bit 0 is 1 and the receive queue holds 4 or more frames. Identify bit 1 is set when control bit 1 is 1 and the transmit queue holds 4 or fewer frames.
- R8: When rx_push arrives with the port enabled and 8 frames held, the frame is dropped and an overrun flag latches. Identify bit 2 shows the flag when control bit 2 is 1. Any write to offset 0x14 clears the flag.
- R9: With control bit 3 set, ser_in follows ser_out and ser_ext is ignored. With bit 3 clear, ser_in follows ser_ext.
- R10: irq is the OR of the three identify bits. Writing 0 to the control word therefore forces irq low.
- R11: Both queues deliver frames in arrival order.
- R12: When wide is 0, a data write pushes wdata[7:0] zero-extended and a data read returns only the low byte of the frame. Control bits 5 and 6 are stored and read back only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the receive queue at the data offset) |
| addr | input | 5 | Byte offset |
| wide | input | 1 | 1 = 16-bit data access, 0 = 8-bit |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid in the cycle of rd_en |
| frame_cfg | output | 16 | Frame-format word to the engine |
| clk_prescale | output | 8 | Prescaler to the engine |
| port_en | output | 1 | Port enable |
| tx_valid | output | 1 | Transmit frame available |
| tx_data | output | 16 | Oldest transmit frame |
| tx_pop | input | 1 | Engine takes the transmit frame |
| rx_push | input | 1 | Engine delivers a received frame |
| rx_data | input | 16 | Received frame |
| eng_busy | input | 1 | Engine is shifting |
| ser_out | input | 1 | Engine serial output |
| ser_ext | input | 1 | External serial input |
| ser_in | output | 1 | Serial input to the engine |
| irq | output | 1 | Combined interrupt |

## Verification
On every cycle, the assertions check four things: the queue occupancies stay bounded, a disabled port never offers a transmit frame, an empty data read yields zero, and the overrun flag sets and clears on the right events. A push to a full transmit queue is also checked to leave the occupancy unchanged. Only the bench's sweeps can show frame ordering, because that needs the values returned over a whole fill and drain. The same holds for the interrupt thresholds at each occupancy from 0 to 8, the byte-access truncation and the loopback routing.

// File: rtl/ssp_regfile.sv
module ssp_regfile #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic          wide,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic [DW-1:0] frame_cfg,
  output logic [7:0]    clk_prescale,
  output logic          port_en,
  output logic          tx_valid,
  output logic [DW-1:0] tx_data,
  input  logic          tx_pop,
  input  logic          rx_push,
  input  logic [DW-1:0] rx_data,
  input  logic          eng_busy,
  input  logic          ser_out,
  input  logic          ser_ext,
  output logic          ser_in,
  output logic          irq
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);
  localparam logic [CW-1:0] HALF  = CW'(DEPTH / 2);

  localparam logic [2:0] A_FMT = 3'd0, A_CTL = 3'd1, A_DAT = 3'd2,
                         A_STA = 3'd3, A_PSC = 3'd4, A_IID = 3'd5;

  logic [2:0] sel;
  assign sel = addr[4:2];
  wire unused_lsb = &{1'b0, addr[1:0]};

  logic [6:0] ctl;
  logic       ror_flag;

  logic [DW-1:0] txq [DEPTH];
  logic [DW-1:0] rxq [DEPTH];
  logic [PW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_cnt, rx_cnt;

  assign port_en = ctl[4];

  logic tx_full, tx_empty, rx_full, rx_empty;
  assign tx_full  = tx_cnt == FULLC;
  assign tx_empty = tx_cnt == '0;
  assign rx_full  = rx_cnt == FULLC;
  assign rx_empty = rx_cnt == '0;

  logic tx_in, tx_out, rx_in, rx_out, ovr_evt, iid_wr;
  assign tx_in   = wr_en && sel == A_DAT && !tx_full;
  assign tx_out  = tx_pop && port_en && !tx_empty;
  assign rx_in   = rx_push && port_en && !rx_full;
  assign ovr_evt = rx_push && port_en && rx_full;
  assign rx_out  = rd_en && sel == A_DAT && !rx_empty;
  assign iid_wr  = wr_en && sel == A_IID;

  logic [DW-1:0] wnarrow;
  assign wnarrow = wide ? wdata : {{(DW-8){1'b0}}, wdata[7:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_cfg    <= '0;
      clk_prescale <= '0;
      ctl          <= '0;
    end else if (wr_en) begin
      case (sel)
        A_FMT: frame_cfg    <= wdata;
        A_CTL: ctl          <= wdata[6:0];
        A_PSC: clk_prescale <= wdata[7:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       ror_flag <= 1'b0;
    else if (ovr_evt) ror_flag <= 1'b1;
    else if (iid_wr)  ror_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_cnt <= '0;
    end else begin
      if (tx_in) begin
        txq[tx_wp] <= wnarrow;
        tx_wp <= tx_wp + 1'b1;
      end
      if (tx_out) tx_rp <= tx_rp + 1'b1;
      tx_cnt <= tx_cnt + CW'(tx_in) - CW'(tx_out);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_cnt <= '0;
    end else begin
      if (rx_in) begin
        rxq[rx_wp] <= rx_data;
        rx_wp <= rx_wp + 1'b1;
      end
      if (rx_out) rx_rp <= rx_rp + 1'b1;
      rx_cnt <= rx_cnt + CW'(rx_in) - CW'(rx_out);
    end
  end

  assign tx_valid = port_en && !tx_empty;
  assign tx_data  = txq[tx_rp];
  assign ser_in   = ctl[3] ? ser_out : ser_ext;

  logic [2:0] iid;
  assign iid[0] = ctl[0] && rx_cnt >= HALF;
  assign iid[1] = ctl[1] && tx_cnt <= HALF;
  assign iid[2] = ctl[2] && ror_flag;
  assign irq    = |iid;

  logic busy;
  assign busy = port_en && (!tx_empty || eng_busy);

  logic [DW-1:0] rx_head;
  assign rx_head = rx_empty ? '0 :
                   wide ? rxq[rx_rp] : {{(DW-8){1'b0}}, rxq[rx_rp][7:0]};

  always_comb begin
    case (sel)
      A_FMT:   rdata = frame_cfg;
      A_CTL:   rdata = {{(DW-7){1'b0}}, ctl};
      A_DAT:   rdata = rx_head;
      A_STA:   rdata = {{(DW-5){1'b0}}, busy, rx_full, !rx_empty, !tx_full, tx_empty};
      A_PSC:   rdata = {{(DW-8){1'b0}}, clk_prescale};
      A_IID:   rdata = {{(DW-3){1'b0}}, iid};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/ssp_regfile_chk.sv
module ssp_regfile_chk #(
  parameter int DW    = 16,
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          port_en,
  input logic          tx_valid,
  input logic          rx_push,
  input logic          tx_pop,
  input logic          wr_en,
  input logic          rd_en,
  input logic [2:0]    sel,
  input logic [DW-1:0] rdata,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt,
  input logic          ror_flag
);
  // R3
  fifo_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= CW'(DEPTH) && rx_cnt <= CW'(DEPTH));

  // R6
  off_no_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> !tx_valid);

  // R4
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && sel == 3'd2 && rx_cnt == '0) |-> rdata == '0);

  // R8
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && port_en && rx_cnt == CW'(DEPTH)) |=> ror_flag);

  // R8
  ovr_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 3'd5 && !(rx_push && port_en && rx_cnt == CW'(DEPTH))) |=> !ror_flag);

  // R3
  tx_full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == 3'd2 && tx_cnt == CW'(DEPTH) && !(tx_pop && port_en)) |=> $stable(tx_cnt));
endmodule

bind ssp_regfile ssp_regfile_chk #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .port_en(port_en), .tx_valid(tx_valid),
  .rx_push(rx_push), .tx_pop(tx_pop), .wr_en(wr_en), .rd_en(rd_en),
  .sel(sel), .rdata(rdata), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .ror_flag(ror_flag)
);

// File: tb/ssp_regfile_test.sv
module ssp_regfile_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0, wide = 1;
  logic [4:0] addr = 0;
  logic [15:0] wdata = 0, rdata, frame_cfg, tx_data, rx_data = 0;
  logic [7:0] clk_prescale;
  logic port_en, tx_valid, tx_pop = 0, rx_push = 0, eng_busy = 0;
  logic ser_out = 0, ser_ext = 0, ser_in, irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ssp_regfile uut (.*);

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [4:0] a, logic [15:0] d, logic w = 1);
    @(negedge clk); wr_en = 1; addr = a; wdata = d; wide = w;
    @(posedge clk); #1 wr_en = 0; wide = 1;
  endtask

  task automatic bus_rd(logic [4:0] a, output logic [15:0] d, input logic w = 1);
    @(negedge clk); rd_en = 1; addr = a; wide = w;
    #1 d = rdata;
    @(posedge clk); #1 rd_en = 0; wide = 1;
  endtask

  task automatic eng_pop(output logic v, output logic [15:0] d);
    @(negedge clk); tx_pop = 1; #1 v = tx_valid; d = tx_data;
    @(posedge clk); #1 tx_pop = 0;
  endtask

  task automatic eng_push(logic [15:0] d);
    @(negedge clk); rx_push = 1; rx_data = d;
    @(posedge clk); #1 rx_push = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic vb;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 reset state
    bus_rd(5'h00, v); check("R1 fmt", v, 16'h0);
    bus_rd(5'h04, v); check("R1 ctl", v, 16'h0);
    bus_rd(5'h10, v); check("R1 psc", v, 16'h0);
    bus_rd(5'h0C, v); check("R1 status", v, 16'h0003);
    check("R1 irq", {15'b0, irq}, 16'h0);

    // R2 decode and widths
    bus_wr(5'h00, 16'hA5C7); bus_rd(5'h00, v); check("R2 fmt", v, 16'hA5C7);
    check("R2 frame_cfg", frame_cfg, 16'hA5C7);
    bus_wr(5'h10, 16'h1234); bus_rd(5'h10, v); check("R2 psc", v, 16'h0034);
    check("R2 clk_prescale", {8'h0, clk_prescale}, 16'h0034);
    bus_wr(5'h04, 16'hFFEF); bus_rd(5'h04, v); check("R2 R12 ctl", v, 16'h006F);
    bus_rd(5'h18, v); check("R2 unmapped", v, 16'h0);

    // enable, rx/tx/ovr interrupts on
    bus_wr(5'h04, 16'h0017);
    bus_rd(5'h14, v); check("R7 tx int empty", v, 16'h0002);
    check("R10 irq", {15'b0, irq}, 16'h1);

    // R3 R5 R7 transmit fill sweep, 10 pushes into 8 slots
    for (int i = 0; i < 10; i++) begin
      int c;
      c = (i + 1 > 8) ? 8 : i + 1;
      bus_wr(5'h08, 16'h0101 * i + 16'h1000);
      bus_rd(5'h0C, v);
      check("R3 R5 status", v, {11'b0, 1'b1, 1'b0, 1'b0, c < 8, 1'b0});
      bus_rd(5'h14, v);
      check("R7 tx int", v, {14'b0, c <= 4, 1'b0});
    end
    // R11 R3 drain order
    for (int i = 0; i < 8; i++) begin
      eng_pop(vb, v);
      check("R11 tx valid", {15'b0, vb}, 16'h1);
      check("R11 tx order", v, 16'h0101 * i + 16'h1000);
    end
    check("R3 tx empty", {15'b0, tx_valid}, 16'h0);

    // R7 R8 receive fill sweep with overrun
    for (int i = 0; i < 9; i++) begin
      int c;
      c = (i + 1 > 8) ? 8 : i + 1;
      eng_push(16'hC000 + 16'h0111 * i);
      bus_rd(5'h0C, v);
      check("R5 rx status", v, {11'b0, 1'b0, c == 8, 1'b1, 1'b1, 1'b1});
      bus_rd(5'h14, v);
      check("R7 R8 identify", v, {13'b0, i == 8, 1'b1, c >= 4});
    end
    // R11 R4 read back, ninth dropped
    for (int i = 0; i < 8; i++) begin
      bus_rd(5'h08, v);
      check("R11 R8 rx order", v, 16'hC000 + 16'h0111 * i);
    end
    bus_rd(5'h08, v); check("R4 empty read", v, 16'h0);
    bus_rd(5'h0C, v); check("R4 empty status", v, 16'h0003);
    bus_rd(5'h14, v); check("R8 ror held", v, 16'h0006);
    bus_wr(5'h14, 16'h0000);
    bus_rd(5'h14, v); check("R8 ror cleared", v, 16'h0002);

    // R12 byte accesses
    eng_push(16'hBEEF);
    bus_rd(5'h08, v, 1'b0); check("R12 narrow read", v, 16'h00EF);
    bus_wr(5'h08, 16'h5634, 1'b0);
    eng_pop(vb, v); check("R12 narrow write", v, 16'h0034);

    // R5 busy from engine
    eng_busy = 1;
    bus_rd(5'h0C, v); check("R5 busy", v, 16'h0013);
    eng_busy = 0;

    // R6 R10 disabled port
    bus_wr(5'h04, 16'h0000);
    check("R10 irq masked", {15'b0, irq}, 16'h0);
    check("R6 port_en", {15'b0, port_en}, 16'h0);
    bus_wr(5'h08, 16'h7777);
    check("R6 no tx_valid", {15'b0, tx_valid}, 16'h0);
    eng_pop(vb, v);
    eng_push(16'h4444);
    bus_rd(5'h0C, v); check("R6 pop/push ignored", v, 16'h0002);
    bus_wr(5'h04, 16'h0010);
    eng_pop(vb, v); check("R6 frame kept", v, 16'h7777);
    bus_rd(5'h08, v); check("R6 rx untouched", v, 16'h0);

    // R9 loopback
    for (int k = 0; k < 4; k++) begin
      bus_wr(5'h04, (k < 2) ? 16'h0018 : 16'h0010);
      for (int p = 0; p < 4; p++) begin
        @(negedge clk); ser_out = p[0]; ser_ext = p[1];
        #1 check("R9 ser_in", {15'b0, ser_in}, {15'b0, (k < 2) ? p[0] : p[1]});
      end
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule